// File: doc/BRIEF.md
# Multiboot Strike-Count Fallback Sequencer

This block decides which flash start address each configuration attempt reads from, and when to stop trying. It tracks one of three images (the header at address 0, the multiboot image, the fallback image) and keeps one strike counter that all three share. Every counted error adds one strike. Crossing fixed thresholds moves the next attempt from the multiboot image to the fallback image. The next threshold sends it back to address 0 for a second round. When the second round is spent, the block halts and drives the INIT and DONE pins low.

A counted error, or a header-issued reconfiguration command, produces a one-cycle restart request and loads the start address for the next attempt. A successful attempt freezes the sequencer. Only power-up reset (`rst_n`) or a hard reboot pulse (`hard_reboot`) returns the block to the header with zero strikes. Loading the bitstream, decoding the header and timing the watchdog all happen outside this block.

Top module: `multiboot_fallback_seq`

## Requirements
- R1: After `rst_n` low or a `hard_reboot` pulse, `strike_cnt` is 0, `start_addr` is 0, `restart_req` is 0, `init_low` and `done_low` are 0, and the header is the active image in the first round.
- R2: In the header image, each counted error adds a strike. The block restarts at address 0 while the new count is below the header limit (3 in the first round, 9 in the second) and halts when the count reaches that limit. An `iprog` pulse restarts at `multi_addr` and leaves the count unchanged.
- R3: A `crc_err` pulse is counted only when `reset_on_err` is 1. With `reset_on_err` at 0, a lone `crc_err` changes neither the count, the address nor `restart_req`.
- R4: A `wdog_timeout` pulse is counted whatever the level of `reset_on_err`.
- R5: In the first round, a counted error in the multiboot image restarts at `multi_addr` while the new count is below 3. When the count reaches 3, the block restarts at `fallback_addr` and the fallback image becomes active.
- R6: In the first round, a counted error in the fallback image restarts at `fallback_addr` while the new count is below 6. When the count reaches 6, the block restarts at address 0 and the second round begins.
- R7: In the second round, an `iprog` pulse in the header moves to the multiboot image. One counted multiboot error moves to the fallback image. Fallback errors restart at `fallback_addr`. Any counted error that brings the count to 9 halts.
- R8: When halted, `init_low` and `done_low` are both 1, no restart is requested, and error, `iprog` and `cfg_done` inputs have no effect until a hard reboot or reset.
- R9: A `cfg_done` pulse with no counted error in the same cycle, while the multiboot or fallback image is active, freezes the sequencer. The count and address stay as they are and later events are ignored. A counted error in the same cycle takes priority over `cfg_done`.
- R10: `strike_cnt` is a 4-bit count equal to the number of counted errors since the last clear. It never exceeds 9.
- R11: `restart_req` is high for exactly the one cycle after each counted error or accepted `iprog` that does not halt, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| hard_reboot | input | 1 | Synchronous full clear (program pin pulse) |
| crc_err | input | 1 | CRC error pulse of the current attempt |
| wdog_timeout | input | 1 | Watchdog timeout pulse of the current attempt |
| reset_on_err | input | 1 | Enables counting of CRC errors |
| iprog | input | 1 | Header finished and issued its reconfiguration command |
| cfg_done | input | 1 | Current attempt completed successfully |
| multi_addr | input | ADDR_W | Flash start address of the multiboot image |
| fallback_addr | input | ADDR_W | Flash start address of the fallback image |
| start_addr | output | ADDR_W | Start address for the next attempt |
| restart_req | output | 1 | One-cycle request to start a new attempt |
| strike_cnt | output | 4 | Shared strike count |
| init_low | output | 1 | Hold INIT low (halted) |
| done_low | output | 1 | Hold DONE low (halted) |

## Verification
The hardest state to reach is the end of the second round. The block has to fall back from the multiboot image, then wrap from the fallback image to address 0, and then take the later strikes at exactly 7, 8 and 9. No hard reboot or successful completion may occur along the way, and any CRC error must arrive with `reset_on_err` high. A directed sequence walks that whole path, checking the address at every threshold. Random stimulus then mixes error kinds, enable levels, `iprog`, completion and rare reboots, with most reboots and completions suppressed so that long strike chains can build up.

// File: rtl/multiboot_fallback_seq.sv
module multiboot_fallback_seq #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_reboot,
  input  logic              crc_err,
  input  logic              wdog_timeout,
  input  logic              reset_on_err,
  input  logic              iprog,
  input  logic              cfg_done,
  input  logic [ADDR_W-1:0] multi_addr,
  input  logic [ADDR_W-1:0] fallback_addr,
  output logic [ADDR_W-1:0] start_addr,
  output logic              restart_req,
  output logic [3:0]        strike_cnt,
  output logic              init_low,
  output logic              done_low
);
  localparam logic [3:0] FIRST_LIM = 4'd3;
  localparam logic [3:0] WRAP_LIM  = 4'd6;
  localparam logic [3:0] FINAL_LIM = 4'd9;

  typedef enum logic [2:0] {S_HDR, S_MULTI, S_FALL, S_BOOTED, S_HALT} st_t;

  st_t              st_q, st_d;
  logic             round2_q, round2_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic             rs_d, rs_q;

  wire       hit = wdog_timeout | (crc_err & reset_on_err);
  wire [3:0] inc = cnt_q + 4'd1;

  always_comb begin
    st_d = st_q; round2_d = round2_q; cnt_d = cnt_q; addr_d = addr_q; rs_d = 1'b0;
    case (st_q)
      S_HDR:
        if (hit) begin
          cnt_d = inc;
          if (inc >= (round2_q ? FINAL_LIM : FIRST_LIM)) st_d = S_HALT;
          else begin addr_d = '0; rs_d = 1'b1; end
        end else if (iprog) begin
          st_d = S_MULTI; addr_d = multi_addr; rs_d = 1'b1;
        end
      S_MULTI:
        if (hit) begin
          cnt_d = inc;
          if (round2_q && inc >= FINAL_LIM) st_d = S_HALT;
          else if (round2_q || inc >= FIRST_LIM) begin
            st_d = S_FALL; addr_d = fallback_addr; rs_d = 1'b1;
          end else begin
            addr_d = multi_addr; rs_d = 1'b1;
          end
        end else if (cfg_done) st_d = S_BOOTED;
      S_FALL:
        if (hit) begin
          cnt_d = inc;
          if (round2_q) begin
            if (inc >= FINAL_LIM) st_d = S_HALT;
            else begin addr_d = fallback_addr; rs_d = 1'b1; end
          end else if (inc >= WRAP_LIM) begin
            st_d = S_HDR; round2_d = 1'b1; addr_d = '0; rs_d = 1'b1;
          end else begin
            addr_d = fallback_addr; rs_d = 1'b1;
          end
        end else if (cfg_done) st_d = S_BOOTED;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_HDR; round2_q <= 1'b0; cnt_q <= '0; addr_q <= '0; rs_q <= 1'b0;
    end else if (hard_reboot) begin
      st_q <= S_HDR; round2_q <= 1'b0; cnt_q <= '0; addr_q <= '0; rs_q <= 1'b0;
    end else begin
      st_q <= st_d; round2_q <= round2_d; cnt_q <= cnt_d; addr_q <= addr_d; rs_q <= rs_d;
    end
  end

  assign start_addr  = addr_q;
  assign restart_req = rs_q;
  assign strike_cnt  = cnt_q;
  assign init_low    = (st_q == S_HALT);
  assign done_low    = (st_q == S_HALT);

  assert_reboot_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hard_reboot |=> (strike_cnt == 4'd0 && start_addr == '0 && !restart_req));

  assert_crc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !reset_on_err && !wdog_timeout && !hard_reboot) |=> $stable(strike_cnt));

  assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_low && !hard_reboot) |=> (init_low && done_low && $stable(strike_cnt) && !restart_req));

  assert_count_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strike_cnt <= FINAL_LIM);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_reboot |=> (strike_cnt == $past(strike_cnt) || strike_cnt == $past(strike_cnt) + 4'd1));

  assert_restart_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> $past(crc_err || wdog_timeout || iprog));
endmodule

// File: tb/tb_multiboot_fallback_seq.sv
module tb_multiboot_fallback_seq;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hard_reboot = 0, crc_err = 0, wdog_timeout = 0, reset_on_err = 0, iprog = 0, cfg_done = 0;
  logic [AW-1:0] multi_addr = 24'h400000, fallback_addr = 24'h000044;
  logic [AW-1:0] start_addr;
  logic restart_req, init_low, done_low;
  logic [3:0] strike_cnt;

  multiboot_fallback_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .hard_reboot(hard_reboot), .crc_err(crc_err),
    .wdog_timeout(wdog_timeout), .reset_on_err(reset_on_err), .iprog(iprog),
    .cfg_done(cfg_done), .multi_addr(multi_addr), .fallback_addr(fallback_addr),
    .start_addr(start_addr), .restart_req(restart_req), .strike_cnt(strike_cnt),
    .init_low(init_low), .done_low(done_low));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  // model: 0 header, 1 multi, 2 fallback, 3 booted, 4 halted
  int m_st = 0, m_cnt = 0;
  bit m_r2 = 0, m_rs = 0;
  logic [AW-1:0] m_addr = '0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string st_tag(int s, bit r2);
    if (s == 4) return "R8";
    if (s == 3) return "R9";
    if (r2) return "R7";
    if (s == 0) return "R2";
    if (s == 1) return "R5";
    return "R6";
  endfunction

  task automatic model(bit c, bit w, bit r, bit d, bit ip, bit hr);
    bit hit;
    int nc;
    m_rs = 0;
    if (hr) begin m_st = 0; m_r2 = 0; m_cnt = 0; m_addr = '0; return; end
    hit = w || (c && r);
    nc = m_cnt + 1;
    if (m_st == 0) begin
      if (hit) begin
        m_cnt = nc;
        if (nc >= (m_r2 ? 9 : 3)) m_st = 4; else begin m_addr = '0; m_rs = 1; end
      end else if (ip) begin m_st = 1; m_addr = multi_addr; m_rs = 1; end
    end else if (m_st == 1) begin
      if (hit) begin
        m_cnt = nc;
        if (m_r2 && nc >= 9) m_st = 4;
        else if (m_r2 || nc >= 3) begin m_st = 2; m_addr = fallback_addr; m_rs = 1; end
        else begin m_addr = multi_addr; m_rs = 1; end
      end else if (d) m_st = 3;
    end else if (m_st == 2) begin
      if (hit) begin
        m_cnt = nc;
        if (m_r2) begin
          if (nc >= 9) m_st = 4; else begin m_addr = fallback_addr; m_rs = 1; end
        end else if (nc >= 6) begin m_st = 0; m_r2 = 1; m_addr = '0; m_rs = 1; end
        else begin m_addr = fallback_addr; m_rs = 1; end
      end else if (d) m_st = 3;
    end
  endtask

  task automatic cyc(bit c, bit w, bit r, bit d, bit ip, bit hr);
    string t;
    crc_err = c; wdog_timeout = w; reset_on_err = r; cfg_done = d; iprog = ip; hard_reboot = hr;
    t = hr ? "R1" : st_tag(m_st, m_r2);
    @(posedge clk);
    model(c, w, r, d, ip, hr);
    @(negedge clk);
    crc_err = 0; wdog_timeout = 0; cfg_done = 0; iprog = 0; hard_reboot = 0;
    chk({t, " addr"}, int'(start_addr), int'(m_addr));
    chk("R10 strike count", int'(strike_cnt), m_cnt);
    chk("R11 restart", int'(restart_req), int'(m_rs));
    chk("R8 init_low", int'(init_low), int'(m_st == 4));
    chk("R8 done_low", int'(done_low), int'(m_st == 4));
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(strike_cnt), 0);
    chk("R1 reset addr", int'(start_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset restart", int'(restart_req), 0);
    chk("R1 reset halt", int'(init_low), 0);

    // R3: CRC with reset_on_err low is ignored
    repeat (4) cyc(1, 0, 0, 0, 0, 0);
    chk("R3 gated crc count", int'(strike_cnt), 0);
    // R4: watchdog counts with reset_on_err low; header halts at 3 (R2)
    cyc(0, 1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    chk("R4 wdog count", int'(strike_cnt), 2);
    cyc(1, 0, 1, 0, 0, 0);
    chk("R2 header halt", int'(init_low), 1);
    // R8: halted ignores events
    cyc(1, 1, 1, 1, 1, 0);
    chk("R8 halted count", int'(strike_cnt), 3);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R1 reboot count", int'(strike_cnt), 0);

    // full path to 9
    cyc(0, 0, 0, 0, 1, 0);
    chk("R2 iprog addr", int'(start_addr), int'(multi_addr));
    repeat (3) cyc(1, 0, 1, 0, 0, 0);
    chk("R5 to fallback", int'(start_addr), int'(fallback_addr));
    repeat (3) cyc(0, 1, 0, 0, 0, 0);
    chk("R6 wrap addr", int'(start_addr), 0);
    chk("R6 wrap count", int'(strike_cnt), 6);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R7 second multi to fallback", int'(start_addr), int'(fallback_addr));
    cyc(0, 1, 0, 0, 0, 0);
    chk("R7 count 8", int'(strike_cnt), 8);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R7 halt at 9", int'(done_low), 1);
    chk("R10 final count", int'(strike_cnt), 9);

    // R9: done freezes; error wins over same-cycle done
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R9 error beats done", int'(strike_cnt), 1);
    cyc(0, 0, 0, 1, 0, 0);
    repeat (3) cyc(1, 1, 1, 0, 1, 0);
    chk("R9 frozen count", int'(strike_cnt), 1);
    chk("R9 frozen addr", int'(start_addr), int'(multi_addr));

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit c, w, r, d, ip, hr;
      c = ($urandom % 4) == 0; w = ($urandom % 5) == 0; r = $urandom % 2;
      d = ($urandom % 40) == 0; ip = ($urandom % 3) == 0; hr = ($urandom % 70) == 0;
      if (hr) begin
        multi_addr = AW'($urandom); fallback_addr = AW'($urandom);
        cyc(0, 0, r, 0, 0, 1);
      end else cyc(c, w, r, d, ip, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule